// File: doc/BRIEF.md
# Implicit-Length Packed String Comparator

This block compares two 128-bit vectors. Each vector holds a fragment of a zero-terminated string. A control byte sets how the vectors are read: sixteen bytes or eight 16-bit words, signed or unsigned values, one of four ways of combining the per-element comparisons, an optional inversion of the result, and the layout of the output.

An element counts as part of its string only if it comes before the first zero element. The combined result has one bit per element of operand B. It is returned either as a packed bit field in the low bits of the output, or spread so that each bit fills its whole element. Six status flags come with the result. They report whether the result is nonzero, whether either operand contains a terminator, and the value of the first result bit.

A start strobe loads the operands. The result, the flags and a one-cycle done strobe appear on the next clock edge. The outputs then hold until the next start.

Top module: `istr_cmp`

## Requirements
- R1: Control bit 0 selects the element size: 0 gives sixteen 8-bit elements, 1 gives eight 16-bit elements. Element e occupies bits [e*W +: W]. In word mode, result bits for element positions 8 to 15 are 0.
- R2: An element is valid only if every element at a lower index is nonzero and the element itself is nonzero. A zero element, and every element above it, is invalid.
- R3: Control bit 6 = 0 places the final result bits in result_o[15:0] (bits [7:0] in word mode) and drives all higher bits to 0. Control bit 6 = 1 fills each element's field in result_o with all ones when its result bit is 1, and with all zeros otherwise.
- R4: flags_o[0] (carry) is 1 exactly when the final result is nonzero.
- R5: flags_o[3] (zero) is 1 when operand B contains a zero element. flags_o[4] (sign) is 1 when operand A contains a zero element.
- R6: flags_o[5] (overflow) equals bit 0 of the final result. flags_o[1] and flags_o[2] are always 0.
- R7: With control bits 3:2 = 00 (match any), result bit k is 1 when B element k is valid and equals some valid A element.
- R8: With control bits 3:2 = 01 (ranges), A elements 2p and 2p+1 form an inclusive lower/upper bound pair. Result bit k is 1 when valid B element k lies within some pair whose two elements are both valid. Control bit 1 = 1 compares the values as signed, and 0 compares them as unsigned.
- R9: With control bits 3:2 = 10 (match each), result bit k compares A element k with B element k. If both are valid the bit is their equality. If both are invalid the bit is 1. If exactly one is valid the bit is 0.
- R10: With control bits 3:2 = 11 (ordered), result bit k is the AND, over every i with k+i below the element count, of one term per i. The term is 1 if A element i is invalid. Otherwise it is 0 if B element k+i is invalid. Otherwise it is the equality of the two elements.
- R11: Control bit 4 = 0 leaves the result unchanged. Bits 5:4 = 01 invert every result bit. Bits 5:4 = 11 invert only the bits at valid B positions.
- R12: done_o pulses for one cycle, one clock after start_i. result_o and flags_o change only on that edge and hold otherwise. After reset, all outputs are 0. Control bit 6 has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load operands and control |
| ctrl_i | input | 8 | Control byte |
| opa_i | input | 128 | Operand A (set, ranges or needle) |
| opb_i | input | 128 | Operand B (searched string) |
| result_o | output | 128 | Registered result |
| flags_o | output | 6 | Registered status flags |
| done_o | output | 1 | Result valid strobe |

## Verification
The hardest cases to reach from the ports are the ordered search near the top of the vector and the signed ranges. In the ordered search, a partial needle match runs past the last element and must be treated as true. In the signed ranges, a bound pair holds values of opposite sign. Random operands rarely produce either case. The stimulus therefore draws bytes from a small alphabet that includes zero, 0x80 and 0xFF, so matches, terminators and sign crossings all occur often. Directed strings add a needle that straddles the terminator and a bound pair that is empty when read as unsigned.

// File: rtl/istr_pkg.sv
package istr_pkg;
  typedef enum logic [1:0] {
    AGG_ANY   = 2'b00,
    AGG_RANGE = 2'b01,
    AGG_EACH  = 2'b10,
    AGG_ORDER = 2'b11
  } agg_e;

  localparam int FLG_CF = 0;
  localparam int FLG_PF = 1;
  localparam int FLG_AF = 2;
  localparam int FLG_ZF = 3;
  localparam int FLG_SF = 4;
  localparam int FLG_OF = 5;
  localparam int FLG_W  = 6;

  localparam int CB_WORD   = 0;
  localparam int CB_SIGNED = 1;
  localparam int CB_NEG    = 4;
  localparam int CB_MASKED = 5;
  localparam int CB_EXPAND = 6;
endpackage

// File: rtl/istr_unpack.sv
module istr_unpack #(
  parameter int DATA_W = 128,
  localparam int NB = DATA_W / 8,
  localparam int NW = DATA_W / 16,
  localparam int XW = 17
) (
  input  logic [DATA_W-1:0]       data_i,
  input  logic                    word_i,
  input  logic                    signed_i,
  output logic [NB-1:0][XW-1:0]   elem_o,
  output logic [NB-1:0]           valid_o,
  output logic [NB-1:0]           exist_o,
  output logic                    has_null_o
);
  logic [NB-1:0] is_null;

  for (genvar e = 0; e < NB; e++) begin : g_elem
    logic [7:0]  bv;
    logic [15:0] wv;
    assign bv = data_i[e*8 +: 8];
    if (e < NW) begin : g_w
      assign wv = data_i[e*16 +: 16];
      assign exist_o[e] = 1'b1;
    end else begin : g_nw
      assign wv = 16'h0;
      assign exist_o[e] = !word_i;
    end
    // sign or zero extend to a common compare width
    assign elem_o[e] = word_i ? {signed_i & wv[15], wv}
                              : {{9{signed_i & bv[7]}}, bv};
    assign is_null[e] = exist_o[e] & (word_i ? (wv == 16'h0) : (bv == 8'h0));
  end

  always_comb begin
    logic run;
    run = 1'b1;
    for (int e = 0; e < NB; e++) begin
      run = run & exist_o[e] & !is_null[e];
      valid_o[e] = run;
    end
  end

  assign has_null_o = |is_null;
endmodule

// File: rtl/istr_aggregate.sv
module istr_aggregate
  import istr_pkg::*;
#(
  parameter int NB = 16,
  localparam int NW = NB / 2,
  localparam int NP = NB / 2,
  localparam int XW = 17
) (
  input  logic [NB-1:0][XW-1:0] a_elem_i,
  input  logic [NB-1:0][XW-1:0] b_elem_i,
  input  logic [NB-1:0]         a_valid_i,
  input  logic [NB-1:0]         b_valid_i,
  input  logic [NB-1:0]         exist_i,
  input  logic                  word_i,
  input  agg_e                  agg_i,
  output logic [NB-1:0]         res_o
);
  // row index: B element, column index: A element
  logic [NB-1:0][NB-1:0] eq_m;
  logic [NB-1:0][NB-1:0] rng_m;
  logic [NB-1:0][NB-1:0] ord_t;
  logic [NB-1:0][NP-1:0] pair_hit;
  logic [NB-1:0] any_res, rng_res, each_res, ord_res;

  for (genvar k = 0; k < NB; k++) begin : g_row
    for (genvar i = 0; i < NB; i++) begin : g_col
      assign eq_m[k][i] = (a_elem_i[i] == b_elem_i[k]);
      if (i % 2 == 0) begin : g_lo
        assign rng_m[k][i] = $signed(b_elem_i[k]) >= $signed(a_elem_i[i]);
      end else begin : g_hi
        assign rng_m[k][i] = $signed(b_elem_i[k]) <= $signed(a_elem_i[i]);
      end
    end
    for (genvar p = 0; p < NP; p++) begin : g_pair
      assign pair_hit[k][p] = a_valid_i[2*p] & a_valid_i[2*p+1]
                            & rng_m[k][2*p] & rng_m[k][2*p+1];
    end
  end

  // ordered search terms; positions past the element count are true
  for (genvar k = 0; k < NB; k++) begin : g_ord
    for (genvar i = 0; i < NB; i++) begin : g_term
      if (k + i < NW) begin : g_in
        assign ord_t[k][i] = !a_valid_i[i] | (b_valid_i[k+i] & eq_m[k+i][i]);
      end else if (k + i < NB) begin : g_bonly
        assign ord_t[k][i] = word_i | !a_valid_i[i] | (b_valid_i[k+i] & eq_m[k+i][i]);
      end else begin : g_out
        assign ord_t[k][i] = 1'b1;
      end
    end
    assign ord_res[k]  = &ord_t[k];
    assign any_res[k]  = b_valid_i[k] & |(eq_m[k] & a_valid_i);
    assign rng_res[k]  = b_valid_i[k] & |pair_hit[k];
    assign each_res[k] = (a_valid_i[k] & b_valid_i[k]) ? eq_m[k][k]
                                                       : (!a_valid_i[k] & !b_valid_i[k]);
  end

  always_comb begin
    unique case (agg_i)
      AGG_ANY:   res_o = any_res;
      AGG_RANGE: res_o = rng_res;
      AGG_EACH:  res_o = each_res;
      default:   res_o = ord_res;
    endcase
    res_o = res_o & exist_i;
  end
endmodule

// File: rtl/istr_finish.sv
module istr_finish #(
  parameter int DATA_W = 128,
  localparam int NB = DATA_W / 8,
  localparam int NW = DATA_W / 16
) (
  input  logic [NB-1:0]     res1_i,
  input  logic [NB-1:0]     b_valid_i,
  input  logic [NB-1:0]     exist_i,
  input  logic              word_i,
  input  logic              neg_i,
  input  logic              masked_i,
  input  logic              expand_i,
  output logic [NB-1:0]     res2_o,
  output logic [DATA_W-1:0] result_o
);
  logic [NB-1:0]     flip;
  logic [DATA_W-1:0] byte_exp, word_exp;

  assign flip   = !neg_i ? '0 : (masked_i ? b_valid_i : exist_i);
  assign res2_o = (res1_i ^ flip) & exist_i;

  for (genvar e = 0; e < NB; e++) begin : g_bexp
    assign byte_exp[e*8 +: 8] = {8{res2_o[e]}};
  end
  for (genvar e = 0; e < NW; e++) begin : g_wexp
    assign word_exp[e*16 +: 16] = {16{res2_o[e]}};
  end

  always_comb begin
    if (expand_i) result_o = word_i ? word_exp : byte_exp;
    else          result_o = {{(DATA_W-NB){1'b0}}, res2_o};
  end
endmodule

// File: rtl/istr_cmp.sv
module istr_cmp
  import istr_pkg::*;
#(
  parameter int DATA_W = 128,
  localparam int NB = DATA_W / 8,
  localparam int NW = DATA_W / 16,
  localparam int XW = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        ctrl_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLG_W-1:0]  flags_o,
  output logic              done_o
);
  logic                  word, sgn;
  logic [NB-1:0][XW-1:0] a_elem, b_elem;
  logic [NB-1:0]         a_valid, b_valid, b_exist, a_exist_unused;
  logic                  a_null, b_null;
  logic [NB-1:0]         res1, res2;
  logic [DATA_W-1:0]     result_d;
  logic [FLG_W-1:0]      flags_d;
  logic                  fmt_q, word_q;
  logic                  ctrl_unused;
  agg_e                  agg;

  assign word        = ctrl_i[CB_WORD];
  assign sgn         = ctrl_i[CB_SIGNED];
  assign agg         = agg_e'(ctrl_i[3:2]);
  assign ctrl_unused = ctrl_i[7];

  istr_unpack #(.DATA_W(DATA_W)) u_unpack_a (
    .data_i(opa_i), .word_i(word), .signed_i(sgn),
    .elem_o(a_elem), .valid_o(a_valid), .exist_o(a_exist_unused), .has_null_o(a_null)
  );

  istr_unpack #(.DATA_W(DATA_W)) u_unpack_b (
    .data_i(opb_i), .word_i(word), .signed_i(sgn),
    .elem_o(b_elem), .valid_o(b_valid), .exist_o(b_exist), .has_null_o(b_null)
  );

  istr_aggregate #(.NB(NB)) u_agg (
    .a_elem_i(a_elem), .b_elem_i(b_elem), .a_valid_i(a_valid), .b_valid_i(b_valid),
    .exist_i(b_exist), .word_i(word), .agg_i(agg), .res_o(res1)
  );

  istr_finish #(.DATA_W(DATA_W)) u_fin (
    .res1_i(res1), .b_valid_i(b_valid), .exist_i(b_exist), .word_i(word),
    .neg_i(ctrl_i[CB_NEG]), .masked_i(ctrl_i[CB_MASKED]), .expand_i(ctrl_i[CB_EXPAND]),
    .res2_o(res2), .result_o(result_d)
  );

  always_comb begin
    flags_d         = '0;
    flags_d[FLG_CF] = |res2;
    flags_d[FLG_ZF] = b_null;
    flags_d[FLG_SF] = a_null;
    flags_d[FLG_OF] = res2[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flags_o  <= '0;
      done_o   <= 1'b0;
      fmt_q    <= 1'b0;
      word_q   <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        result_o <= result_d;
        flags_o  <= flags_d;
        fmt_q    <= ctrl_i[CB_EXPAND];
        word_q   <= word;
      end
    end
  end

  p_done_follows_start_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  p_done_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  p_hold_outputs_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(result_o) && $stable(flags_o)));
  p_valid_prefix_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((((a_valid + 1'b1) & a_valid) == '0) && (((b_valid + 1'b1) & b_valid) == '0)));
  p_word_upper_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word |-> (res2[NB-1:NW] == '0));
  p_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flags_o[FLG_CF] == (result_o != '0)));
  p_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flags_o[FLG_OF] == result_o[0]));
  p_af_pf_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_o[FLG_AF] && !flags_o[FLG_PF]);
  p_packed_upper_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fmt_q) |-> (result_o[DATA_W-1:NB] == '0));
  p_word_packed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fmt_q && word_q) |-> (result_o[NB-1:NW] == '0));
endmodule

// File: tb/istr_cmp_tb_top.sv
`timescale 1ns/1ps
module istr_cmp_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [7:0]   ctrl_i = '0;
  logic [127:0] opa_i = '0, opb_i = '0;
  logic [127:0] result_o;
  logic [5:0]   flags_o;
  logic         done_o;

  int    n_chk = 0, n_fail = 0;
  bit    mon_en = 1'b0;
  string cur_tag = "R12 reset", exp_tag = "R12 reset";
  logic         exp_done = 1'b0;
  logic [127:0] exp_res = '0;
  logic [5:0]   exp_flg = '0;

  always #4 clk_i = ~clk_i;

  istr_cmp dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ctrl_i(ctrl_i),
    .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o), .flags_o(flags_o), .done_o(done_o)
  );

  function automatic void ref_model(input logic [127:0] a, input logic [127:0] b,
                                    input logic [7:0] c, output logic [127:0] r,
                                    output logic [5:0] f);
    int n, ew;
    int av[16], bv[16];
    bit va[16], vb[16];
    bit za, zb, run, ok;
    logic [15:0] r1, r2;
    n = c[0] ? 8 : 16;
    ew = c[0] ? 16 : 8;
    za = 0; zb = 0; r1 = '0; r = '0; f = '0;
    for (int e = 0; e < 16; e++) begin av[e] = 0; bv[e] = 0; va[e] = 0; vb[e] = 0; end
    run = 1;
    for (int e = 0; e < n; e++) begin
      av[e] = c[0] ? int'(a[e*16 +: 16]) : int'(a[e*8 +: 8]);
      if (av[e] == 0) begin za = 1; run = 0; end
      va[e] = run;
      if (c[1] && av[e] >= (1 << (ew-1))) av[e] -= (1 << ew);
    end
    run = 1;
    for (int e = 0; e < n; e++) begin
      bv[e] = c[0] ? int'(b[e*16 +: 16]) : int'(b[e*8 +: 8]);
      if (bv[e] == 0) begin zb = 1; run = 0; end
      vb[e] = run;
      if (c[1] && bv[e] >= (1 << (ew-1))) bv[e] -= (1 << ew);
    end
    for (int k = 0; k < n; k++) begin
      case (c[3:2])
        2'b00: for (int i = 0; i < n; i++)
                 if (va[i] && vb[k] && av[i] == bv[k]) r1[k] = 1;
        2'b01: for (int p = 0; p + 1 < n; p += 2)
                 if (va[p] && va[p+1] && vb[k] && bv[k] >= av[p] && bv[k] <= av[p+1]) r1[k] = 1;
        2'b10: r1[k] = (va[k] && vb[k]) ? (av[k] == bv[k]) : (!va[k] && !vb[k]);
        default: begin
          ok = 1;
          for (int i = 0; k + i < n; i++) begin
            if (!va[i]) ok = ok;
            else if (!vb[k+i]) ok = 0;
            else if (av[i] != bv[k+i]) ok = 0;
          end
          r1[k] = ok;
        end
      endcase
    end
    r2 = r1;
    if (c[4]) for (int k = 0; k < n; k++) if (!c[5] || vb[k]) r2[k] = !r1[k];
    f[0] = |r2; f[3] = zb; f[4] = za; f[5] = r2[0];
    if (c[6]) begin
      for (int k = 0; k < n; k++) for (int t = 0; t < ew; t++) r[k*ew + t] = r2[k];
    end else r[15:0] = r2;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_done <= 1'b0; exp_res <= '0; exp_flg <= '0;
    end else begin
      logic [127:0] r;
      logic [5:0]   f;
      exp_done <= start_i;
      if (start_i) begin
        ref_model(opa_i, opb_i, ctrl_i, r, f);
        exp_res <= r; exp_flg <= f; exp_tag <= cur_tag;
      end
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (mon_en) begin
      chk("R12 done strobe", {127'b0, done_o}, {127'b0, exp_done});
      chk({exp_tag, " result"}, result_o, exp_res);
      chk("R4 carry flag", {127'b0, flags_o[0]}, {127'b0, exp_flg[0]});
      chk("R5 zero flag", {127'b0, flags_o[3]}, {127'b0, exp_flg[3]});
      chk("R5 sign flag", {127'b0, flags_o[4]}, {127'b0, exp_flg[4]});
      chk("R6 overflow flag", {127'b0, flags_o[5]}, {127'b0, exp_flg[5]});
      chk("R6 aux/parity flags", {126'b0, flags_o[2:1]}, {126'b0, exp_flg[2:1]});
    end
  end

  task automatic go(input logic [127:0] a, input logic [127:0] b,
                    input logic [7:0] c, input string tag);
    @(negedge clk_i);
    opa_i = a; opb_i = b; ctrl_i = c; cur_tag = tag; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    opa_i = ~a; ctrl_i = ~c;
  endtask

  function automatic logic [7:0] pick();
    int x;
    x = $urandom_range(0, 15);
    case (x)
      0:       return 8'h00;
      1, 2:    return 8'h80;
      3, 4:    return 8'hFF;
      5, 6:    return 8'h01;
      7, 8, 9: return 8'h41;
      default: return 8'h42;
    endcase
  endfunction

  localparam logic [127:0] HELLO = 128'h0000_0000_0064_6c72_6f77_206f_6c6c_6568;

  initial begin
    repeat (3) @(negedge clk_i);
    mon_en = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R7 vowels in a sentence, packed and expanded
    go(128'h0000_0000_0000_0000_0000_0075_6f69_6561, HELLO, 8'h00, "R7 any");
    go(128'h0000_0000_0000_0000_0000_0075_6f69_6561, HELLO, 8'h40, "R12 bit6 flags R3 expand");
    // R8 letter range; signed pair crossing zero
    go(128'h7a61, HELLO, 8'h04, "R8 range");
    go(128'h10F0, 128'h8020_F505, 8'h06, "R8 signed range");
    go(128'h10F0, 128'h8020_F505, 8'h04, "R8 unsigned range");
    // R9 and R11 polarity variants
    go(128'h6f_6c6c_6568, 128'h706c_6568, 8'h08, "R9 each");
    go(128'h6f_6c6c_6568, 128'h706c_6568, 8'h18, "R11 invert all");
    go(128'h6f_6c6c_6568, 128'h706c_6568, 8'h38, "R11 invert valid");
    go(128'h6f_6c6c_6568, 128'h706c_6568, 8'h28, "R11 pass x0");
    // R10 needle search, needle straddling the end
    go(128'h6f6c, HELLO, 8'h0C, "R10 ordered");
    go(128'h6f6c, HELLO, 8'h4C, "R10 ordered R3 expand");
    go(128'h4241, {16'h4241, 112'h4141_4141_4141_4141_4141_4141_4141}, 8'h0C, "R10 ordered tail");
    // R1 word elements
    go(128'h1234_00ff_0041, 128'h0042_1234_0041_0042, 8'h01, "R1 word any");
    go(128'h1234_00ff_0041, 128'h0042_1234_0041_0042, 8'h41, "R1 word R3 expand");
    go({8{16'h0041}}, {8{16'h0041}}, 8'h19, "R1 word invert");
    // R2 empty string and full-length string
    go(128'h0, 128'h0102_0304_0506_0708_090a_0b0c_0d0e_0f10, 8'h00, "R2 empty A");
    go(128'h05, 128'h0102_0304_0506_0708_090a_0b0c_0d0e_0f10, 8'h00, "R2 full B");
    go({16{8'h41}}, {16{8'h41}}, 8'h08, "R5 no nulls");
    go(128'h41_0000_0000_0041, 128'h41_0000_0041, 8'h08, "R2 bytes past null");
    for (int v = 0; v < 600; v++) begin
      logic [127:0] a, b;
      logic [7:0]   c;
      for (int j = 0; j < 16; j++) begin a[j*8 +: 8] = pick(); b[j*8 +: 8] = pick(); end
      c = 8'($urandom);
      case (c[3:2])
        2'b00:   go(a, b, c, "R7 rnd");
        2'b01:   go(a, b, c, "R8 rnd");
        2'b10:   go(a, b, c, "R9 rnd");
        default: go(a, b, c, "R10 rnd");
      endcase
      if (v % 3 == 0) @(negedge clk_i);
    end
    repeat (3) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule